// File: doc/BRIEF.md
# Timer-Assisted General-Purpose I/O Port

This block controls a group of general-purpose pins through a small synchronous register bus. Software stores an output data byte and a direction byte, and reads back the synchronized pin levels through a read-only input register. Each pin drives a pad output value and a pad output enable. A pin whose direction bit is 0 is a high-impedance input.

A timer output-compare channel can take over any single pin. While the channel's compare-enable bit is set, the pin is driven as an output and carries the timer's compare value. The software-written direction bit is not changed. When the compare enable drops, the direction bit controls the pin again.

A capture tap gives the synchronized level of every pin to an input-capture unit, whatever the pin's mode. The synchronized level lets software compare the value it drives with the level actually on the pin, and so find a shorted or overloaded output.

Top module: `gpio_tmr_port`

## Requirements
- R1: After reset, the data register and the direction register both read 0. With all compare enables low, `pad_oe` and `pad_out` are 0.
- R2: The direction register at offset 2 can be written and read at any time. Bit n = 1 sets `pad_oe[n]`, and bit n = 0 clears it when compare n is off. The change appears in the cycle after the write edge.
- R3: The data register at offset 0 can be written and read at any time. `pad_out[n]` equals data bit n when `cmp_en[n]` is 0.
- R4: A read at offset 1 returns `pad_in` as it was SYNC_STAGES rising edges earlier (2 by default). This holds in input and output modes alike.
- R5: A write to offset 1 has no effect: the data and direction registers keep their values.
- R6: While `cmp_en[n]` is 1, `pad_oe[n]` is 1 and `pad_out[n]` equals `cmp_val[n]`, whatever direction bit n holds.
- R7: Compare enables never modify the direction register. Its readback stays the written value, and when `cmp_en[n]` returns to 0, direction bit n again sets `pad_oe[n]`.
- R8: `cap_tap` equals `pad_in` delayed by SYNC_STAGES rising edges, in every pin mode.
- R9: Reads at any offset other than 0, 1 and 2 return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, sampled on rising edge |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the current offset (combinational) |
| pad_in | input | W | Raw pin levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| cmp_en | input | W | Per-pin timer compare enable |
| cmp_val | input | W | Per-pin timer compare output value |
| cap_tap | output | W | Synchronized pin levels for input capture |

## Verification
The bench builds the block with W = 8, SYNC_STAGES = 2 and ADDR_W = 3. The wider offset field puts five unmapped offsets in reach, so reads of zero and writes with no effect can be tested away from offset 3 alone. Eight pins let the random stimulus mix input, output and compare-owned pins in one byte. With a two-stage synchronizer, the bench checks both the one-edge point, where the old level must still show, and the two-edge point, where the new level must appear.

// File: rtl/gpio_tmr_pkg.sv
package gpio_tmr_pkg;

    // Register offsets; the order is fixed because software decodes it.
    localparam int unsigned OFF_DATA = 0;
    localparam int unsigned OFF_IN   = 1;
    localparam int unsigned OFF_DIR  = 2;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_IN   = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    function automatic reg_sel_e decode_off(input logic [15:0] off);
        case (off)
            16'(OFF_DATA): return SEL_DATA;
            16'(OFF_IN):   return SEL_IN;
            16'(OFF_DIR):  return SEL_DIR;
            default:       return SEL_NONE;
        endcase
    endfunction

    // Compare ownership wins over the software direction and data.
    function automatic pin_drive_t pick_drive(input logic dir_bit,
                                              input logic data_bit,
                                              input logic cmp_on,
                                              input logic cmp_bit);
        pin_drive_t d;
        if (cmp_on) begin
            d.oe  = 1'b1;
            d.val = cmp_bit;
        end else begin
            d.oe  = dir_bit;
            d.val = data_bit;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_tmr_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q
);
    reg_sel_e sel;

    assign sel = decode_off(16'(addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (we) begin
            // The input register and unmapped offsets take no writes.
            if (sel == SEL_DATA) data_q <= wdata;
            if (sel == SEL_DIR)  dir_q  <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_DATA: rdata = data_q;
            SEL_IN:   rdata = pin_sync;
            SEL_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] cmp_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        pin_drive_t drv;
        assign drv        = pick_drive(dir_q[n], data_q[n], cmp_en[n], cmp_val[n]);
        assign pad_oe[n]  = drv.oe;
        assign pad_out[n] = drv.val;
    end
endmodule

// File: rtl/gpio_tmr_port.sv
module gpio_tmr_port #(
    parameter int W           = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    input  logic [W-1:0]      cmp_en,
    input  logic [W-1:0]      cmp_val,
    output logic [W-1:0]      cap_tap
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pin_sync)
    );

    gpio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .data_q   (data_q),
        .dir_q    (dir_q)
    );

    gpio_pad_mux #(.W(W)) u_mux (
        .dir_q   (dir_q),
        .data_q  (data_q),
        .cmp_en  (cmp_en),
        .cmp_val (cmp_val),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign cap_tap = pin_sync;
endmodule

// File: rtl/gpio_tmr_port_chk.sv
module gpio_tmr_port_chk
    import gpio_tmr_pkg::*;
#(
    parameter int W           = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      cmp_en,
    input logic [W-1:0]      cmp_val,
    input logic [W-1:0]      cap_tap,
    input logic [W-1:0]      data_q,
    input logic [W-1:0]      dir_q
);
    logic [1:0] live_cnt;

    always_ff @(posedge clk) begin
        if (rst) live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    AST_CMP_FORCES_OE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & cmp_en) == cmp_en); // R6

    AST_CMP_OWNS_VALUE: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ cmp_val) & cmp_en) == '0); // R6

    AST_IN_REG_RO: assert property (@(posedge clk) disable iff (rst)
        (bus_we && decode_off(16'(bus_addr)) == SEL_IN) |=> ($stable(data_q) && $stable(dir_q))); // R5

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && decode_off(16'(bus_addr)) == SEL_DIR) |=> $stable(dir_q)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        decode_off(16'(bus_addr)) == SEL_NONE |-> bus_rdata == '0); // R9

    if (SYNC_STAGES == 2) begin : g_tap
        AST_TAP_LAG: assert property (@(posedge clk) disable iff (rst)
            live_cnt >= 2'd2 |-> cap_tap == $past(pad_in, 2)); // R8
    end
endmodule

bind gpio_tmr_port gpio_tmr_port_chk #(
    .W(W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .cmp_en    (cmp_en),
    .cmp_val   (cmp_val),
    .cap_tap   (cap_tap),
    .data_q    (data_q),
    .dir_q     (dir_q)
);

// File: tb/gpio_tmr_port_tb.sv
`timescale 1ns/1ps
module gpio_tmr_port_tb;
    localparam int W  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic [W-1:0]  bus_wdata;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_oe;
    logic [W-1:0]  cmp_en;
    logic [W-1:0]  cmp_val;
    logic [W-1:0]  cap_tap;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [W-1:0] m_data, m_dir;

    always #2.5 clk = ~clk;

    gpio_tmr_port #(.W(W), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .cmp_en(cmp_en),
        .cmp_val(cmp_val), .cap_tap(cap_tap)
    );

    function automatic logic [W-1:0] exp_oe(logic [W-1:0] dir, logic [W-1:0] en);
        return dir | en;
    endfunction

    function automatic logic [W-1:0] exp_out(logic [W-1:0] dat, logic [W-1:0] en, logic [W-1:0] v);
        return (en & v) | (~en & dat);
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [W-1:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 0) m_data = v;
        if (a == 2) m_dir  = v;
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a, logic [W-1:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] h1, h2;
        void'($urandom(32'd4242));
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        pad_in = '0; cmp_en = '0; cmp_val = '0;
        m_data = '0; m_dir = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd_chk("R1 data", 3'd0, 8'h00);
        rd_chk("R1 dir",  3'd2, 8'h00);
        chk("R1 oe",  pad_oe,  8'h00);
        chk("R1 out", pad_out, 8'h00);
        rst = 1'b0;

        // R2: direction write and readback
        wr(3'd2, 8'hA5);
        rd_chk("R2 dir readback", 3'd2, 8'hA5);
        chk("R2 oe", pad_oe, 8'hA5);
        // R3: data register
        wr(3'd0, 8'h3C);
        rd_chk("R3 data readback", 3'd0, 8'h3C);
        chk("R3 out", pad_out, 8'h3C);
        // R6: compare takes over low nibble
        cmp_en = 8'h0F; cmp_val = 8'h05;
        #0.5;
        chk("R6 oe forced", pad_oe, 8'hAF);
        chk("R6 out value", pad_out, 8'h35);
        // R7: direction unaffected, regains control
        rd_chk("R7 dir kept", 3'd2, 8'hA5);
        wr(3'd2, 8'h00);
        chk("R7 oe while cmp", pad_oe, 8'h0F);
        cmp_en = 8'h00;
        #0.5;
        chk("R7 oe after cmp off", pad_oe, 8'h00);
        chk("R7 out after cmp off", pad_out, 8'h3C);
        // R5: input register ignores writes
        wr(3'd1, 8'hFF);
        rd_chk("R5 data kept", 3'd0, 8'h3C);
        rd_chk("R5 dir kept",  3'd2, 8'h00);
        // R9: unmapped offsets
        wr(3'd5, 8'hFF);
        rd_chk("R9 data kept", 3'd0, 8'h3C);
        rd_chk("R9 dir kept",  3'd2, 8'h00);
        for (int a = 3; a < 8; a++) rd_chk("R9 unmapped read", AW'(a), 8'h00);
        // R4/R8: two-edge latency, in input then output mode
        wr(3'd2, 8'hFF);
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        chk("R8 tap one edge", cap_tap, 8'h00);
        @(negedge clk);
        chk("R8 tap two edges", cap_tap, 8'h5A);
        rd_chk("R4 input reg out mode", 3'd1, 8'h5A);

        // Random mix, one cycle per iteration
        h1 = pad_in; h2 = pad_in;
        bus_we = 1'b0;
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            if (bus_we && bus_addr == 0) m_data = bus_wdata;
            if (bus_we && bus_addr == 2) m_dir  = bus_wdata;
            #0.5;
            chk("R8 tap random", cap_tap, h2);
            chk("R6 oe random", pad_oe, exp_oe(m_dir, cmp_en));
            chk("R3 out random", pad_out, exp_out(m_data, cmp_en, cmp_val));
            case (bus_addr)
                3'd0: chk("R3 read random", bus_rdata, m_data);
                3'd1: chk("R4 read random", bus_rdata, h2);
                3'd2: chk("R7 read random", bus_rdata, m_dir);
                default: chk("R9 read random", bus_rdata, 8'h00);
            endcase
            h2 = h1;
            bus_addr  = AW'($urandom_range(0, 7));
            bus_we    = ($urandom_range(0, 2) == 0);
            bus_wdata = W'($urandom);
            cmp_en    = W'($urandom) & W'($urandom);
            cmp_val   = W'($urandom);
            pad_in    = W'($urandom);
            h1 = pad_in;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule